// File: doc/BRIEF.md
# Condition Register Field Unit

This block holds a 32-bit condition register organised as eight 4-bit fields and applies every update the execution core can request. One command is accepted per cycle, chosen by a 2-bit command code. The first command is a field-masked move: it takes a 32-bit source value and an 8-bit field mask, and each mask bit controls whether its 4-bit field is replaced from the source. The second is a record update of field 0 from a 4-bit value supplied by the arithmetic unit. The third writes the outcome of a conditional store into field 0.

Field 0 is the most significant nibble, bits 31:28. Within it, bit 31 is less-than, bit 30 is greater-than, bit 29 is equal and bit 28 is summary-overflow. The whole register is always available on a read port, so a move-from-register operation needs no command. The register changes on the clock edge after a command is presented.

Top module: `crf_unit`

## Requirements
- R1: When reset (synchronous, active low) is asserted at a clock edge, the register holds 0x00000000 after that edge.
- R2: The read port always shows the current register value. A cycle with command code 0 (idle) leaves the register unchanged.
- R3: With command code 1 (masked move), mask bit i set replaces register bits 4i+3..4i with the same bits of the source value on the next edge.
- R4: With command code 1, every field whose mask bit is 0 keeps its previous contents.
- R5: With command code 1, mask 0xFF replaces the whole register, and mask 0x00 leaves it unchanged.
- R6: With command code 2 (record update), bits 31:28 take the 4-bit record value and bits 27:0 are unchanged.
- R7: With command code 3 (conditional store) and success=1, bits 31:28 become LT=0, GT=0, EQ=1 and SO equal to the summary-overflow input. Bits 27:0 are unchanged.
- R8: With command code 3 and success=0, LT, GT and EQ are cleared and SO equals the summary-overflow input. Bits 27:0 are unchanged.
- R9: Inputs that the current command does not use have no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 2 | Command: 0 idle, 1 masked move, 2 record update, 3 conditional store |
| src_val | input | 32 | Source value for the masked move |
| fld_mask | input | 8 | Per-field enable for the masked move; bit i selects field bits 4i+3..4i |
| rec_val | input | 4 | Field-0 value for the record update |
| st_ok | input | 1 | Conditional store succeeded |
| sum_ovf | input | 1 | Current summary-overflow flag |
| cr_out | output | 32 | Current register value |

## Verification
The assertions assume that every input is a known value, never X, at each clock edge after reset. They also take the command code to be the only selector, so there is never a second simultaneous write to arbitrate. The stimulus meets these conditions by driving every input to a defined value on the falling edge, including inputs the command ignores. Those unused inputs are deliberately set to conflicting values so that any leakage shows up in the result.

// File: rtl/crf_pkg.sv
// Package: shared widths and command encoding for the condition register unit.
// Assumes eight fields of four bits; field 0 is the top nibble.
package crf_pkg;
    localparam int unsigned FIELDS  = 8;
    localparam int unsigned FW      = 4;
    localparam int unsigned CRW     = FIELDS * FW;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_MOVE  = 2'd1,
        CMD_REC   = 2'd2,
        CMD_STCX  = 2'd3
    } crf_cmd_e;

    // Bit order inside field 0 (within the nibble, msb first).
    localparam int unsigned B_LT = 3;
    localparam int unsigned B_GT = 2;
    localparam int unsigned B_EQ = 1;
    localparam int unsigned B_SO = 0;
endpackage

// File: rtl/crf_mask_expand.sv
// Module: crf_mask_expand
// Expands a per-field mask into per-field write enables, gated by a move request.
// Assumes field i of the register occupies bits FW*i+FW-1 .. FW*i.
module crf_mask_expand #(
    parameter int unsigned FIELDS = 8
) (
    input  logic              move_en,
    input  logic [FIELDS-1:0] mask,
    output logic [FIELDS-1:0] fld_we
);
    for (genvar i = 0; i < FIELDS; i++) begin : g_we
        // Gate each field's mask bit by the move request.
        always_comb fld_we[i] = move_en & mask[i];
    end
endmodule

// File: rtl/crf_cr0_gen.sv
// Module: crf_cr0_gen
// Builds the new top-field value for the record-update and conditional-store commands.
// Assumes the caller only uses the result when one of those commands is active.
module crf_cr0_gen #(
    parameter int unsigned FW = 4
) (
    input  logic          is_stcx,
    input  logic [FW-1:0] rec_val,
    input  logic          st_ok,
    input  logic          sum_ovf,
    output logic [FW-1:0] cr0_new
);
    import crf_pkg::*;
    // Pick the record value or compose the store-conditional result.
    always_comb begin
        cr0_new = rec_val;
        if (is_stcx) begin
            cr0_new       = '0;
            cr0_new[B_EQ] = st_ok;
            cr0_new[B_SO] = sum_ovf;
        end
    end
endmodule

// File: rtl/crf_field.sv
// Module: crf_field
// One 4-bit field register with two write ports; the move port wins when both are active.
// Assumes synchronous active-low reset to zero.
module crf_field #(
    parameter int unsigned FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mv_we,
    input  logic [FW-1:0] mv_d,
    input  logic          c0_we,
    input  logic [FW-1:0] c0_d,
    output logic [FW-1:0] q
);
    // Hold, load from the move port, or load the top-field value.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (mv_we) q <= mv_d;
        else if (c0_we) q <= c0_d;
    end
endmodule

// File: rtl/crf_unit.sv
// Module: crf_unit (top)
// Condition register of FIELDS nibbles with masked move, top-field record update and
// conditional-store result. One command per cycle; the value is always on cr_out.
// Assumes field 0 maps to the most significant nibble and mask bit i to bits FW*i+FW-1..FW*i.
module crf_unit #(
    parameter int unsigned FIELDS = 8,
    parameter int unsigned FW     = 4,
    localparam int unsigned CRW   = FIELDS * FW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic [CRW-1:0]    src_val,
    input  logic [FIELDS-1:0] fld_mask,
    input  logic [FW-1:0]     rec_val,
    input  logic              st_ok,
    input  logic              sum_ovf,
    output logic [CRW-1:0]    cr_out
);
    import crf_pkg::*;

    localparam int unsigned TOP = FIELDS - 1;

    crf_cmd_e        cmd_e;
    logic            move_en;
    logic            c0_en;
    logic [FIELDS-1:0] fld_we;
    logic [FW-1:0]   cr0_new;

    // Decode the command code into write requests.
    always_comb begin
        cmd_e   = crf_cmd_e'(cmd);
        move_en = (cmd_e == CMD_MOVE);
        c0_en   = (cmd_e == CMD_REC) || (cmd_e == CMD_STCX);
    end

    crf_mask_expand #(.FIELDS(FIELDS)) u_expand (
        .move_en (move_en),
        .mask    (fld_mask),
        .fld_we  (fld_we)
    );

    crf_cr0_gen #(.FW(FW)) u_cr0 (
        .is_stcx (cmd_e == CMD_STCX),
        .rec_val (rec_val),
        .st_ok   (st_ok),
        .sum_ovf (sum_ovf),
        .cr0_new (cr0_new)
    );

    for (genvar i = 0; i < FIELDS; i++) begin : g_fld
        if (i == TOP) begin : g_top
            crf_field #(.FW(FW)) u_f (
                .clk   (clk),
                .rst_n (rst_n),
                .mv_we (fld_we[i]),
                .mv_d  (src_val[FW*i +: FW]),
                .c0_we (c0_en),
                .c0_d  (cr0_new),
                .q     (cr_out[FW*i +: FW])
            );
        end else begin : g_low
            crf_field #(.FW(FW)) u_f (
                .clk   (clk),
                .rst_n (rst_n),
                .mv_we (fld_we[i]),
                .mv_d  (src_val[FW*i +: FW]),
                .c0_we (1'b0),
                .c0_d  ('0),
                .q     (cr_out[FW*i +: FW])
            );
        end
    end
endmodule

// File: rtl/crf_unit_chk.sv
// Module: crf_unit_chk
// Checker bound to crf_unit; relates commands to the register value one edge later.
// Assumes inputs are known after reset.
module crf_unit_chk #(
    parameter int unsigned FIELDS = 8,
    parameter int unsigned FW     = 4,
    localparam int unsigned CRW   = FIELDS * FW
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cmd,
    input logic [CRW-1:0]    src_val,
    input logic [FIELDS-1:0] fld_mask,
    input logic [FW-1:0]     rec_val,
    input logic              st_ok,
    input logic              sum_ovf,
    input logic [CRW-1:0]    cr_out
);
    localparam int unsigned LOW = CRW - FW;

    logic [CRW-1:0] bitmask;
    // Widen the field mask to a bit mask for the move check.
    always_comb
        for (int i = 0; i < FIELDS; i++) bitmask[FW*i +: FW] = {FW{fld_mask[i]}};

    // R1: reset gives zero.
    assert_reset_zero_R1: assert property (@(posedge clk) !rst_n |=> cr_out == '0);
    // R2: idle holds.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'd0 |=> $stable(cr_out));
    // R3, R4, R5: masked move.
    assert_move_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'd1 |=> cr_out == (($past(src_val) & $past(bitmask)) | ($past(cr_out) & ~$past(bitmask))));
    // R6: record update.
    assert_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'd2 |=> cr_out == {$past(rec_val), $past(cr_out[LOW-1:0])});
    // R7: successful conditional store.
    assert_stcx_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd3 && st_ok) |=> cr_out == {3'b001, $past(sum_ovf), $past(cr_out[LOW-1:0])});
    // R8: failed conditional store.
    assert_stcx_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd3 && !st_ok) |=> cr_out == {3'b000, $past(sum_ovf), $past(cr_out[LOW-1:0])});
endmodule

bind crf_unit crf_unit_chk #(.FIELDS(FIELDS), .FW(FW)) u_chk (.*);

// File: tb/crf_unit_bench.sv
module crf_unit_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  cmd = 0;
    logic [31:0] src_val = 0;
    logic [7:0]  fld_mask = 0;
    logic [3:0]  rec_val = 0;
    logic        st_ok = 0;
    logic        sum_ovf = 0;
    logic [31:0] cr_out;
    int checks = 0, fails = 0;
    logic [31:0] model = 0;

    always #5 clk = ~clk;

    crf_unit u_crf_unit (.*);

    task automatic chk(string req, logic [31:0] exp);
        checks++;
        if (cr_out !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, cr_out, exp);
        end
    endtask

    // Drive one command on the falling edge, wait past the next rising edge.
    task automatic step(logic [1:0] c, logic [31:0] s, logic [7:0] m, logic [3:0] r, logic ok, logic so);
        @(negedge clk);
        cmd = c; src_val = s; fld_mask = m; rec_val = r; st_ok = ok; sum_ovf = so;
        @(negedge clk);
        cmd = 0;
    endtask

    function automatic logic [31:0] mv(logic [31:0] old, logic [31:0] s, logic [7:0] m);
        logic [31:0] r = old;
        for (int i = 0; i < 8; i++) if (m[i]) r[4*i +: 4] = s[4*i +: 4];
        return r;
    endfunction

    task automatic t_reset;
        step(1, 32'hFFFF_FFFF, 8'hFF, 4'hF, 1, 1);
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        chk("R1", 32'h0);
        rst_n = 1; model = 0;
    endtask

    task automatic t_full_and_none;
        step(1, 32'hA5C3_1E7B, 8'hFF, 4'h0, 0, 0); model = 32'hA5C3_1E7B;
        chk("R5 full", model);
        step(1, 32'h1234_5678, 8'h00, 4'hF, 1, 1);
        chk("R5 none", model);
    endtask

    task automatic t_partial;
        logic [31:0] s [3] = '{32'h1111_1111, 32'hFEDC_BA98, 32'h0F0F_0F0F};
        logic [7:0]  m [3] = '{8'h81, 8'h5A, 8'h0C};
        for (int k = 0; k < 3; k++) begin
            step(1, s[k], m[k], 4'hF, 1, 1);
            model = mv(model, s[k], m[k]);
            chk("R3/R4", model);
        end
    endtask

    task automatic t_idle;
        step(0, 32'hDEAD_BEEF, 8'hFF, 4'hF, 1, 1);
        chk("R2", model);
        chk("R9 idle", model);
    endtask

    task automatic t_record;
        step(2, 32'hFFFF_FFFF, 8'hFF, 4'h6, 1, 1);
        model = {4'h6, model[27:0]}; chk("R6/R9", model);
        step(2, 32'h0, 8'hFF, 4'h9, 0, 0);
        model = {4'h9, model[27:0]}; chk("R6", model);
    endtask

    task automatic t_stcx;
        step(3, 32'hFFFF_FFFF, 8'hFF, 4'hF, 1, 0);
        model = {4'b0010, model[27:0]}; chk("R7 so0", model);
        step(3, 32'h0, 8'h00, 4'h0, 1, 1);
        model = {4'b0011, model[27:0]}; chk("R7 so1", model);
        step(2, 32'h0, 8'h00, 4'hE, 0, 0);
        model = {4'hE, model[27:0]}; chk("R6 prep", model);
        step(3, 32'hFFFF_FFFF, 8'hFF, 4'hF, 0, 1);
        model = {4'b0001, model[27:0]}; chk("R8 so1", model);
        step(3, 32'hFFFF_FFFF, 8'hFF, 4'hF, 0, 0);
        model = {4'b0000, model[27:0]}; chk("R8 so0", model);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                chk("R1 initial", 32'h0);
                rst_n = 1;
                t_full_and_none();
                t_partial();
                t_idle();
                t_record();
                t_stcx();
                t_reset();
            end
            begin
                repeat (5000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule